// File: doc/BRIEF.md
# Manchester Wake-up Pattern Correlator

The block decides whether a low-frequency transmission is a genuine wake-up request. It receives a demodulated on/off-keyed data bit that is already synchronous to the system clock, and a one-cycle tick enable from a real-time clock. A rising edge on the carrier-detect input starts an attempt. From then on the block times the initial carrier burst and waits for an alternating preamble. It then slides a 16-half-bit Manchester pattern, or the same pattern twice, across the sampled stream. A match raises a wake request that stays up until the host clears it. Every other outcome aborts the attempt with a one-cycle false-wake pulse, which an outside counter can accumulate.

Timing is measured in half-bit slots, called chips here. A chip lasts `bit_code_i + 1` ticks, so the legal codes 3 to 31 give 4 to 32 ticks. The block samples each chip near its middle. Every data edge re-aligns the sampling phase, so a transmitter whose clock drifts against the local tick stays in step. In Manchester terms a chip pair low-then-high encodes symbol 0 and high-then-low encodes symbol 1. The pattern is given as raw chips, so any Manchester-legal sequence can be programmed.

Top module: `wakeup_correlator`

## Requirements
- R1: During and directly after reset, `wake_o` and `false_o` are low.
- R2: A chip lasts `bit_code_i + 1` ticks. Every change of `data_i` and the carrier-detect rising edge restart the chip phase. Within a chip, the data is sampled on tick number `(bit_code_i >> 1) + 1`, counted from the chip start at tick 0. With no edge, the phase wraps every `bit_code_i + 1` ticks.
- R3: After carrier detect, while `data_i` stays high, the block counts samples. If the 16th consecutive high sample is taken, the attempt fails. The first low level ends the burst.
- R4: After the burst, at least 4 samples in a row must alternate in value. If they do not within the first 16 samples, the attempt fails. The run can still qualify on the 16th sample.
- R5: Once the preamble has qualified, the pattern must match by the 40th sample counted from the end of the burst, or the attempt fails.
- R6: `pattern_i[15]` is the first chip expected and `pattern_i[0]` the last. The pattern is compared against the most recent samples, starting with the sample after the preamble qualified. Samples taken before the burst ended count as 0.
- R7: Any expected-1 chip received as 0 rejects the window. Expected-0 chips received as 1 are missed zeros. The window matches when the number of missed zeros is at most `tol_i`, which ranges from 0 to 3.
- R8: With `double_i` high, the window is 32 samples and must equal the pattern twice, back to back, under the same tolerance rule.
- R9: `wake_o` rises `bit_code_i + 1` ticks after the sample that completed the match. It then stays high until `clr_i`, and falls the cycle after `clr_i`.
- R10: A failed attempt gives exactly one cycle of `false_o` and returns to idle. A new attempt needs a fresh rising edge of `carrier_i`. `false_o` and `wake_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Real-time-clock tick enable, one cycle wide |
| carrier_i | input | 1 | Carrier-detect level; a rising edge starts an attempt |
| data_i | input | 1 | Demodulated data bit, synchronous to clk_i |
| clr_i | input | 1 | Clears a pending wake request |
| pattern_i | input | 16 | Wake-up pattern in chips, first chip in bit 15 |
| bit_code_i | input | 5 | Chip length code; a chip lasts code+1 ticks |
| tol_i | input | 2 | Number of missed zeros allowed |
| double_i | input | 1 | Requires the pattern twice in a row |
| wake_o | output | 1 | Wake request, held until cleared |
| false_o | output | 1 | One-cycle pulse for each failed attempt |

## Verification
If the sampling phase is skewed or fails to re-align, the match lands a chip early or late. That shows up within two chips as `wake_o` being wrong at a chip boundary. A wrong burst, preamble or total counter moves the failure point or removes it. At the ports this appears as a missing or extra `false_o` pulse, or a wake where a rejection was due, and it becomes visible within at most 40 chips of the burst's end. A fault in the window compare or the missed-zero count changes the outcome of patterns with injected zero-to-one flips, or with a single one-to-zero flip, compared with a chip-level model of the rules.

// File: rtl/wuc_pkg.sv
package wuc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BURST,
    ST_PRE,
    ST_PAT,
    ST_WAIT,
    ST_WAKE
  } wuc_state_e;
endpackage

// File: rtl/wuc_halfbit_timer.sv
module wuc_halfbit_timer #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              data_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              strobe_o
);
  logic              data_q;
  logic              edge_s;
  logic [CODE_W-1:0] ph_q;

  assign edge_s   = data_i ^ data_q;
  // mid-chip sample; an edge cycle never samples
  assign strobe_o = tick_i && !edge_s && !restart_i && (ph_q == (code_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      data_q <= data_i;
      if (restart_i || edge_s) ph_q <= '0;
      else if (tick_i)         ph_q <= (ph_q == code_i) ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/wuc_alt_run.sv
module wuc_alt_run #(
  parameter int MIN_RUN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic strobe_i,
  input  logic bit_i,
  output logic ok_o
);
  localparam int RUN_W = $clog2(MIN_RUN + 1);

  logic [RUN_W-1:0] run_q, run_nx;
  logic             last_q;

  always_comb begin
    if (run_q == '0 || bit_i == last_q) run_nx = RUN_W'(1);
    else if (run_q == RUN_W'(MIN_RUN))  run_nx = run_q;
    else                                run_nx = run_q + 1'b1;
  end

  assign ok_o = strobe_i && (run_nx >= RUN_W'(MIN_RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (clear_i) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (strobe_i) begin
      run_q  <= run_nx;
      last_q <= bit_i;
    end
  end
endmodule

// File: rtl/wuc_pattern_cmp.sv
module wuc_pattern_cmp #(
  parameter int PAT_W = 16,
  parameter int TOL_W = 2
) (
  input  logic [2*PAT_W-1:0] win_i,
  input  logic [PAT_W-1:0]   pat_i,
  input  logic               double_i,
  input  logic [TOL_W-1:0]   tol_i,
  output logic               match_o
);
  localparam int WIN_W = 2 * PAT_W;
  localparam int CNT_W = $clog2(WIN_W + 1);

  logic [WIN_W-1:0] exp_w, care_w;
  logic [CNT_W-1:0] nz;
  logic             hard;

  assign exp_w  = double_i ? {pat_i, pat_i} : {{PAT_W{1'b0}}, pat_i};
  assign care_w = double_i ? {WIN_W{1'b1}}  : {{PAT_W{1'b0}}, {PAT_W{1'b1}}};

  always_comb begin
    nz   = '0;
    hard = 1'b0;
    for (int i = 0; i < WIN_W; i++) begin
      if (care_w[i]) begin
        hard = hard | (exp_w[i] & ~win_i[i]);
        nz   = nz + CNT_W'(~exp_w[i] & win_i[i]);
      end
    end
  end

  assign match_o = !hard && (nz <= CNT_W'(tol_i));
endmodule

// File: rtl/wakeup_correlator.sv
module wakeup_correlator
  import wuc_pkg::*;
#(
  parameter int PAT_W     = 16,
  parameter int CODE_W    = 5,
  parameter int TOL_W     = 2,
  parameter int BURST_LIM = 16,
  parameter int PRE_LIM   = 16,
  parameter int PRE_MIN   = 4,
  parameter int TOT_LIM   = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              carrier_i,
  input  logic              data_i,
  input  logic              clr_i,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic [CODE_W-1:0] bit_code_i,
  input  logic [TOL_W-1:0]  tol_i,
  input  logic              double_i,
  output logic              wake_o,
  output logic              false_o
);
  localparam int WIN_W   = 2 * PAT_W;
  localparam int CNT_MAX = (TOT_LIM > (1 << CODE_W)) ? TOT_LIM : (1 << CODE_W);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  wuc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0] sh_q, sh_nx;
  logic             carrier_q, false_q;
  logic             start_s, strobe_s, pre_ok_s, match_s, run_clr_s;

  assign start_s   = (state_q == ST_IDLE) && carrier_i && !carrier_q;
  assign run_clr_s = (state_q == ST_IDLE) || (state_q == ST_BURST);
  assign sh_nx     = {sh_q[WIN_W-2:0], data_i};

  wuc_halfbit_timer #(.CODE_W(CODE_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .data_i   (data_i),
    .restart_i(start_s),
    .code_i   (bit_code_i),
    .strobe_o (strobe_s)
  );

  wuc_alt_run #(.MIN_RUN(PRE_MIN)) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (run_clr_s),
    .strobe_i(strobe_s && (state_q == ST_PRE)),
    .bit_i   (data_i),
    .ok_o    (pre_ok_s)
  );

  wuc_pattern_cmp #(.PAT_W(PAT_W), .TOL_W(TOL_W)) u_cmp (
    .win_i   (sh_nx),
    .pat_i   (pattern_i),
    .double_i(double_i),
    .tol_i   (tol_i),
    .match_o (match_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      carrier_q <= 1'b0;
      false_q   <= 1'b0;
    end else begin
      carrier_q <= carrier_i;
      false_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_s) begin
          state_q <= ST_BURST;
          cnt_q   <= '0;
        end
        ST_BURST: begin
          if (!data_i) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
            sh_q    <= '0;
          end else if (strobe_s) begin
            if (cnt_q == CNT_W'(BURST_LIM - 1)) begin
              state_q <= ST_IDLE;
              false_q <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PRE: if (strobe_s) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (pre_ok_s) state_q <= ST_PAT;
          else if (cnt_q == CNT_W'(PRE_LIM - 1)) begin
            state_q <= ST_IDLE;
            false_q <= 1'b1;
          end
        end
        ST_PAT: if (strobe_s) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (match_s) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
          end else if (cnt_q == CNT_W'(TOT_LIM - 1)) begin
            state_q <= ST_IDLE;
            false_q <= 1'b1;
          end
        end
        ST_WAIT: if (tick_i) begin
          if (cnt_q == CNT_W'(bit_code_i)) state_q <= ST_WAKE;
          else                             cnt_q   <= cnt_q + 1'b1;
        end
        ST_WAKE: if (clr_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wake_o  = (state_q == ST_WAKE);
  assign false_o = false_q;
endmodule

// File: rtl/wuc_checker.sv
module wuc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic clr_i,
  input logic wake_o,
  input logic false_o
);
  // R10
  false_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    false_o |=> !false_o);
  // R10
  out_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_o && false_o));
  // R9
  wake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !clr_i) |=> wake_o);
  // R9
  wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && clr_i) |=> !wake_o);
  // R9
  wake_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(tick_i));
endmodule

bind wakeup_correlator wuc_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .clr_i  (clr_i),
  .wake_o (wake_o),
  .false_o(false_o)
);

// File: tb/tb_wakeup_correlator.sv
module tb_wakeup_correlator;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick, carrier, data, clr, dbl, wake, fls;
  logic [15:0] pat;
  logic [4:0]  code;
  logic [1:0]  tol;

  int  n_tests = 0, n_fail = 0, nfalse = 0, nchips = 0;
  bit  chips [0:159];

  always #(CLK_P/2) clk = ~clk;

  wakeup_correlator dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .carrier_i(carrier),
    .data_i(data), .clr_i(clr), .pattern_i(pat), .bit_code_i(code),
    .tol_i(tol), .double_i(dbl), .wake_o(wake), .false_o(fls)
  );

  always @(negedge clk) if (rst_n && fls) nfalse++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_list(); nchips = 0; endtask
  task automatic add_bits(input bit v, input int n);
    for (int k = 0; k < n; k++) begin chips[nchips] = v; nchips++; end
  endtask
  task automatic add_alt(input int n);
    for (int k = 0; k < n; k++) begin chips[nchips] = k[0]; nchips++; end
  endtask
  task automatic add_pat(input logic [15:0] p);
    for (int k = 15; k >= 0; k--) begin chips[nchips] = p[k]; nchips++; end
  endtask

  // window ending at chip j, earliest chip first; chips before ps read as 0
  function automatic bit win_ok(input int j, input int ps);
    int len = dbl ? 32 : 16;
    int nz = 0;
    for (int q = 0; q < len; q++) begin
      int pos = j - (len - 1) + q;
      bit e = pat[15 - (q % 16)];
      bit r = (pos >= ps) ? chips[pos] : 1'b0;
      if (e && !r) return 1'b0;
      if (!e && r) nz++;
    end
    return nz <= int'(tol);
  endfunction

  // kind: 1 wake, 2 false, 0 undecided
  task automatic model(output int kind, output int midx);
    int i = 0, cnt = 0, run = 0;
    bit last = 0, inpat = 0;
    kind = 0; midx = -1;
    while (i < nchips && chips[i]) begin
      i++;
      if (i == 16) begin kind = 2; return; end
    end
    for (int j = i; j < nchips; j++) begin
      bit c = chips[j];
      cnt++;
      if (!inpat) begin
        run = (run == 0 || c == last) ? 1 : run + 1;
        last = c;
        if (run >= 4) inpat = 1;
        else if (cnt == 16) begin kind = 2; return; end
      end else begin
        if (win_ok(j, i)) begin kind = 1; midx = j; return; end
        if (cnt == 40) begin kind = 2; return; end
      end
    end
  endtask

  task automatic run_case(input string req);
    int kind, midx;
    model(kind, midx);
    nfalse = 0;
    for (int k = 0; k < nchips; k++) begin
      if (kind == 1 && k == midx + 1) chk(wake == 1'b0, "R9", "wake one chip after match", int'(wake), 0);
      if (kind == 1 && k == midx + 2) chk(wake == 1'b1, "R9", "wake two chips after match", int'(wake), 1);
      data = chips[k];
      carrier = 1'b1;
      for (int u = 0; u <= int'(code); u++) begin
        tick = 1'b1; @(negedge clk);
        tick = 1'b0; @(negedge clk);
      end
    end
    if (kind == 1) begin
      chk(wake == 1'b1, req, "wake at end", int'(wake), 1);
      chk(nfalse == 0, req, "false pulses on wake", nfalse, 0);
    end else begin
      chk(wake == 1'b0, req, "no wake", int'(wake), 0);
      chk(nfalse == (kind == 2 ? 1 : 0), req, "false pulses", nfalse, kind == 2 ? 1 : 0);
    end
    carrier = 1'b0; data = 1'b0; clr = 1'b1; @(negedge clk);
    clr = 1'b0; @(negedge clk);
    chk(wake == 1'b0, "R9", "wake after clear", int'(wake), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] p, input logic [4:0] c, input logic [1:0] t, input logic d);
    pat = p; code = c; tol = t; dbl = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    tick = 0; carrier = 0; data = 0; clr = 0;
    setup(16'h9669, 5'd3, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    chk(wake == 1'b0 && fls == 1'b0, "R1", "outputs in reset", int'({wake, fls}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wake == 1'b0 && fls == 1'b0, "R1", "outputs after reset", int'({wake, fls}), 0);

    // R6 default pattern, R2 shortest chip
    clear_list(); add_bits(1, 3); add_alt(8); add_pat(16'h9669); add_bits(0, 50);
    run_case("R6");
    // R3 burst boundary: 15 high passes, 16 high fails
    clear_list(); add_bits(1, 15); add_alt(6); add_pat(16'h9669); add_bits(0, 50);
    run_case("R3");
    clear_list(); add_bits(1, 20); add_alt(6); add_pat(16'h9669); add_bits(0, 30);
    run_case("R3");
    // R4 no preamble
    clear_list(); add_bits(1, 2); add_bits(0, 30);
    run_case("R4");
    // R5 endless preamble never matches
    clear_list(); add_bits(1, 1); add_alt(60);
    run_case("R5");
    // R7 three missed zeros: tol 3 passes, tol 2 rejects, a lost one rejects
    setup(16'h9669, 5'd5, 2'd3, 1'b0);
    clear_list(); add_bits(1, 2); add_alt(6); add_pat(16'h9669); add_bits(0, 50);
    chips[9] = 1; chips[10] = 1; chips[12] = 1;
    run_case("R7");
    setup(16'h9669, 5'd5, 2'd2, 1'b0);
    run_case("R7");
    setup(16'h9669, 5'd5, 2'd3, 1'b0);
    clear_list(); add_bits(1, 2); add_alt(6); add_pat(16'h9669); add_bits(0, 50);
    chips[8] = 0;
    run_case("R7");
    // R8 double mode: two copies pass, one copy rejects
    setup(16'hA55A, 5'd4, 2'd0, 1'b1);
    clear_list(); add_bits(1, 3); add_alt(6); add_pat(16'hA55A); add_pat(16'hA55A); add_bits(0, 50);
    run_case("R8");
    clear_list(); add_bits(1, 3); add_alt(6); add_pat(16'hA55A); add_bits(0, 50);
    run_case("R8");
    // R2 longest chip
    setup(16'h9669, 5'd31, 2'd0, 1'b0);
    clear_list(); add_bits(1, 2); add_alt(6); add_pat(16'h9669); add_bits(0, 30);
    run_case("R2");
    // R10 failure then valid stream with carrier held: single false, no wake
    setup(16'h9669, 5'd3, 2'd0, 1'b0);
    clear_list(); add_bits(1, 17); add_alt(8); add_pat(16'h9669); add_bits(0, 30);
    run_case("R10");

    for (int n = 0; n < 20; n++) begin
      logic [15:0] rp = 16'($urandom);
      logic        rd = 1'($urandom);
      int          ps;
      setup(rp, 5'(3 + $urandom % 8), 2'($urandom), rd);
      clear_list();
      add_bits(1, $urandom % 18);
      add_alt($urandom % 9);
      ps = nchips;
      add_pat(rp);
      if (rd && ($urandom % 5 != 0)) add_pat(rp);
      for (int f = 0; f < int'($urandom % 4); f++) begin
        int q = ps + int'($urandom % 16);
        if (!rp[15 - (q - ps)]) chips[q] = 1;
      end
      if ($urandom % 6 == 0) chips[ps + int'($urandom % 16)] = 0;
      add_bits(0, 50);
      run_case("R7");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule